// File: doc/BRIEF.md
# Free-Running Event Countdown Timer

This block is a per-core event timer. A single control word holds a down counter in its low field and a sticky expiry flag in its top bit. Software arms an event by writing a tick count; the counter then drops by one on every core clock, and when it steps below zero it reloads its largest value and keeps running. The reload also raises the expiry flag, which stays up until software writes the word again.

A level interrupt follows the flag and is gated by a separate mask bit that software sets and clears through dedicated inputs. The usual sequence is to write a count, clear the mask, take the interrupt when it fires, set the mask again and write the next count. Because the counter never stops, the word read back after expiry also tells how many cycles have passed since the event.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the counter starts two clocks after `rst_ni` rises.

Top module: `evt_countdown_timer`

## Requirements
- R1: While reset is in force, the read word is 0 and `irq_o` is low. Reset leaves the interrupt masked, so `irq_o` stays low after release until the mask is cleared.
- R2: A write loads bits 30:0 of the word from bits 30:0 of `wr_data_i` and clears bit 31 at the same edge. Bit 31 of the write data has no effect.
- R3: With no write and a nonzero count, bits 30:0 fall by exactly one at every clock edge.
- R4: With no write and a count of zero, the next edge loads 0x7FFFFFFF into bits 30:0 and sets bit 31.
- R5: Once set, bit 31 stays set at every later edge, including later reloads, until the next write.
- R6: `irq_o` is a register. After each edge it holds bit 31 AND NOT mask as they stood before that edge.
- R7: `mask_set_i` sets the mask at the next edge and `mask_clr_i` clears it. When both are high, set wins.
- R8: A write of zero makes the next edge reload the count and set bit 31.
- R9: A write takes priority over a decrement or a reload in the same cycle.
- R10: `rd_data_o` always shows {flag, count} from the current register state, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; one count per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data; bits 30:0 are the tick count |
| rd_data_o | output | 32 | Control word: bit 31 flag, bits 30:0 count |
| mask_set_i | input | 1 | Masks the interrupt |
| mask_clr_i | input | 1 | Unmasks the interrupt |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The bound checker checks every cycle that a write loads the count and clears the flag, that a nonzero count drops by one, that zero reloads with the flag set, that the flag stays set, and that the mask inputs and the interrupt register follow their rules. The bench's scenarios are needed to show the complete path from a written count to the interrupt edge at an exact cycle. They also show that bit 31 of the write data is ignored, the immediate expiry after writing zero, a write landing in the reload cycle, the reset state, and the mask winning when both mask inputs are high.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Action the counter takes at the coming edge
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2,
    ACT_WRAP = 2'd3
  } cnt_act_e;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output cnt_act_e         act_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             cnt_en;
  cnt_act_e         act;

  // Action select: a write always wins
  always_comb begin
    if (load_i) begin
      act = ACT_LOAD;
    end else if (cnt_q == CNT_ZERO) begin
      act = ACT_WRAP;
    end else begin
      act = ACT_DEC;
    end
  end

  // Next-state logic
  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    cnt_en = 1'b1;
    unique case (act)
      ACT_LOAD: begin
        cnt_d  = load_val_i;
        flag_d = 1'b0;
      end
      ACT_WRAP: begin
        cnt_d  = CNT_MAX;
        flag_d = 1'b1;
      end
      ACT_DEC: begin
        cnt_d  = cnt_q - CNT_ONE;
      end
      default: begin
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign act_o  = act;

endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  input  logic mask_set_i,
  input  logic mask_clr_i,
  output logic mask_o,
  output logic irq_o
);

  logic mask_q, mask_d, mask_en;
  logic irq_q, irq_d;

  always_comb begin
    mask_en = mask_set_i | mask_clr_i;
    mask_d  = mask_set_i;        // set wins over clear
    irq_d   = flag_i & ~mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/evt_countdown_timer.sv
module evt_countdown_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 31,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned REG_W      = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             mask_set_i,
  input  logic             mask_clr_i,
  output logic             irq_o
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  logic             flag;
  logic             mask_q;
  cnt_act_e         cnt_act;

  tmr_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tmr_down_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .load_i     (wr_en_i),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .cnt_o      (cnt),
    .flag_o     (flag),
    .act_o      (cnt_act)
  );

  tmr_irq_gate u_irq_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .flag_i     (flag),
    .mask_set_i (mask_set_i),
    .mask_clr_i (mask_clr_i),
    .mask_o     (mask_q),
    .irq_o      (irq_o)
  );

  assign rd_data_o = {flag, cnt};

endmodule

// File: rtl/tmr_timer_chk.sv
module tmr_timer_chk #(
  parameter int unsigned CNT_W = 31,
  localparam int unsigned REG_W = CNT_W + 1
) (
  input logic             clk_i,
  input logic             rst_sync_n,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             mask_set_i,
  input logic             mask_clr_i,
  input logic             mask_q,
  input logic             irq_o
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R2: write loads the count and clears the flag
  a_r2_write_load: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    wr_en_i |=> rd_data_o == {1'b0, $past(wr_data_i[CNT_W-1:0])});

  // R3: nonzero count falls by one
  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!wr_en_i && rd_data_o[CNT_W-1:0] != '0) |=>
      rd_data_o[CNT_W-1:0] == $past(rd_data_o[CNT_W-1:0]) - 1'b1);

  // R4: zero reloads with the flag set
  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!wr_en_i && rd_data_o[CNT_W-1:0] == '0) |=> rd_data_o == {1'b1, CMAX});

  // R5: flag is sticky until a write
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!wr_en_i && rd_data_o[CNT_W]) |=> rd_data_o[CNT_W]);

  // R6: masked interrupt stays low
  a_r6_masked_low: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    mask_q |=> !irq_o);

  // R6: flag with open mask raises the interrupt
  a_r6_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!mask_q && rd_data_o[CNT_W]) |=> irq_o);

  // R7: set wins over clear
  a_r7_mask_set: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    mask_set_i |=> mask_q);

  a_r7_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mask_clr_i && !mask_set_i) |=> !mask_q);

endmodule

bind evt_countdown_timer tmr_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .mask_set_i (mask_set_i),
  .mask_clr_i (mask_clr_i),
  .mask_q     (mask_q),
  .irq_o      (irq_o)
);

// File: tb/evt_countdown_timer_bench.sv
`timescale 1ns/1ps
module evt_countdown_timer_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        mask_set;
  logic        mask_clr;
  logic        irq;

  int cyc;
  int n_checks;
  int n_errors;
  bit done;

  // scoreboard queues (parallel)
  int          q_due[$];
  bit          q_irq[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  evt_countdown_timer u_evt_countdown_timer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .mask_set_i (mask_set),
    .mask_clr_i (mask_clr),
    .irq_o      (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_rd(input int due, input logic [31:0] exp, input string tag);
    q_due.push_back(due); q_irq.push_back(1'b0); q_exp.push_back(exp); q_tag.push_back(tag);
  endtask

  task automatic expect_irq(input int due, input logic exp, input string tag);
    q_due.push_back(due); q_irq.push_back(1'b1); q_exp.push_back({31'd0, exp}); q_tag.push_back(tag);
  endtask

  // Model of the word a given number of edges after a load of val
  function automatic logic [31:0] model_word(input logic [30:0] val, input int steps);
    longint s = steps;
    if (s <= longint'(val)) return {1'b0, val - 31'(steps)};
    return {1'b1, 31'h7FFF_FFFF - 31'(s - longint'(val) - 1)};
  endfunction

  // Driver: write at a negedge; returns the cycle where the load is visible
  task automatic arm(input logic [31:0] data, output int base);
    wr_en   = 1'b1;
    wr_data = data;
    base    = cyc + 1;
    expect_rd(base, {1'b0, data[30:0]}, "R2");
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic pulse_mask(input logic s, input logic c, output int at);
    mask_set = s;
    mask_clr = c;
    at       = cyc + 1;
    @(negedge clk);
    mask_set = 1'b0;
    mask_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int i = q_due.size() - 1; i >= 0; i--) begin
      if (q_due[i] == cyc) begin
        if (q_irq[i]) check(q_tag[i], {31'd0, irq}, q_exp[i]);
        else          check(q_tag[i], rd_data, q_exp[i]);
        q_due.delete(i); q_irq.delete(i); q_exp.delete(i); q_tag.delete(i);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int b, m;
    cyc = 0; n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; mask_set = 1'b0; mask_clr = 1'b0;
    idle(4);
    // R1: reset state
    check("R1 word", rd_data, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    rst_n = 1'b1;
    idle(12);
    // R1: masked after reset even though the counter has run through zero
    check("R1 masked", {31'd0, irq}, 32'h0);

    // R2 R3 R4 R10: write with bit 31 set in data; bit 31 ignored
    arm(32'h8000_000A, b);
    expect_rd(b + 3,  model_word(31'd10, 3),  "R3");
    expect_rd(b + 10, model_word(31'd10, 10), "R3 zero");
    expect_rd(b + 11, 32'hFFFF_FFFF,          "R4");
    expect_rd(b + 14, model_word(31'd10, 14), "R10");
    expect_irq(b + 13, 1'b0, "R6 masked");
    idle(20);

    // R5: flag still set long after the reload
    expect_rd(cyc + 1, model_word(31'd10, cyc + 1 - b), "R5");
    idle(2);

    // R6 R7: open the mask while the flag is up
    pulse_mask(1'b0, 1'b1, m);
    expect_irq(m, 1'b0, "R6 delay");
    expect_irq(m + 1, 1'b1, "R6 rise");
    idle(3);

    // write clears flag; interrupt falls one edge later, rises after expiry
    arm(32'd5, b);
    expect_irq(b, 1'b1, "R6 lag");
    expect_irq(b + 1, 1'b0, "R6 fall");
    expect_irq(b + 6, 1'b0, "R6 wait");
    expect_rd(b + 6, 32'hFFFF_FFFF, "R4");
    expect_irq(b + 7, 1'b1, "R6 fire");
    idle(10);

    // R7: set and clear together -> masked
    pulse_mask(1'b1, 1'b1, m);
    expect_irq(m, 1'b1, "R7 lag");
    expect_irq(m + 1, 1'b0, "R7 set wins");
    idle(4);

    // R8: write of zero expires at the next edge
    arm(32'd0, b);
    expect_rd(b + 1, 32'hFFFF_FFFF, "R8");
    idle(4);

    // R9: write in the reload cycle wins
    arm(32'd1, b);
    idle(1);             // now at cycle b+1 with count 0
    arm(32'd7, m);
    expect_rd(m + 1, 32'h0000_0006, "R9");
    idle(6);

    // drain
    while (q_due.size() != 0) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule